// File: doc/BRIEF.md
# DSD-over-PCM Detector and Unpacker

This block sits on a stereo PCM sample stream in which each 32-bit word carries a 24-bit sample in bits 31:8. It looks at the top byte of both channels on every frame to find the marker pattern used to carry one-bit DSD audio inside PCM words. Before the stream is treated as DSD, the markers must alternate correctly for a configurable number of frames in a row, and the configured sample rate must be above 96 kHz. Once the run is complete, the block switches to DoP mode.

In DoP mode each frame carries 16 DSD bits per channel in bits 23:8. The block joins two frames into one 32-bit DSD word per channel and hands the word to a downstream DSD serializer. It also produces a bit-clock enable for that serializer and a fill word that replaces missing data on underflow. The block leaves DoP mode only when both channels lose both marker values. A one-cycle pulse marks every mode change, so the serializer clocks can be stopped cleanly.

Top module: `dop_unpacker`

## Requirements
- R1: After reset the block is in PCM mode (dop_mode=0), with mode_change=0, dsd_valid=0, dsd_bit_en=0 and underflow_fill=0.
- R2: While rate_hz is 96000 or lower, no frame changes the qualification state, so any number of correctly marked frames leaves dop_mode at 0.
- R3: With rate_hz above 96000, a frame matches when both channels carry the expected marker in bits 31:24. The expected marker starts at 0xFA and toggles between 0xFA and 0x05 after each match. The frame that completes ENTRY_RUN consecutive matches (default 32) sets dop_mode to 1, starting in the cycle after that frame.
- R4: In PCM mode with rate_hz above 96000, a frame that does not match clears the run count and resets the expected marker to 0xFA. A full run of ENTRY_RUN new matches is then needed to enter DoP mode. This applies when only one channel is wrong and when the run begins with 0x05.
- R5: In DoP mode, a frame in which at least one channel shows 0x05 or 0xFA in bits 31:24 keeps DoP mode, whatever the order of the markers.
- R6: In DoP mode, frames are used in pairs. Bits 23:8 of the first frame of a pair become bits 31:16 of the channel's DSD word, and bits 23:8 of the second frame become bits 15:0. dsd_valid pulses for one cycle, in the cycle after the second frame, and dsd_left and dsd_right hold the words.
- R7: A DoP-mode frame in which neither channel shows 0x05 or 0xFA returns the block to PCM mode. That frame is not packed, and any half-built pair is dropped, so the next DoP session starts a new pair.
- R8: mode_change is high for exactly one cycle after each entry into DoP mode and after each exit from it.
- R9: underflow_fill is 0xFA969600 in DoP mode and 0x00000000 in PCM mode.
- R10: In DoP mode, dsd_bit_en pulses once every bit_period clock cycles. In PCM mode it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle strobe: a stereo frame is present |
| pcm_left | input | 32 | Left sample, 24 bits in 31:8 |
| pcm_right | input | 32 | Right sample, 24 bits in 31:8 |
| rate_hz | input | RATE_W | Configured sample rate in Hz |
| bit_period | input | PER_W | Clock cycles per DSD bit |
| dop_mode | output | 1 | 1 while in DoP mode |
| mode_change | output | 1 | One-cycle pulse on entry to or exit from DoP mode |
| dsd_valid | output | 1 | One-cycle strobe: new DSD words are present |
| dsd_left | output | 32 | Left DSD word, earliest bit in MSB |
| dsd_right | output | 32 | Right DSD word, earliest bit in MSB |
| dsd_bit_en | output | 1 | DSD bit-clock enable |
| underflow_fill | output | 32 | Word to send when no data is available |

## Verification
The detector is driven with several patterns, each of which separates one rule:
- A fully correct alternating run sent at 96000 Hz shows that the rate gate blocks entry.
- The same run above that rate shows the exact frame on which entry happens: the run length is checked one frame short and then at the threshold.
- A run broken by one bad channel, and a run that starts with the wrong marker, show that the count and the marker phase are both reset.
- In DoP mode, frames that keep a marker on only one channel, or that repeat markers out of order, separate the exit rule from the entry rule.
- Payloads with distinct halves check which frame lands in the upper 16 bits.
- An exit in the middle of a pair, followed by a new entry, shows that the pairing phase restarts.

// File: rtl/dop_pkg.sv
package dop_pkg;
    localparam logic [7:0]  MARK_ODD   = 8'h05;
    localparam logic [7:0]  MARK_EVEN  = 8'hFA;
    localparam logic [31:0] FILL_DOP   = 32'hFA969600;
    localparam logic [31:0] FILL_PCM   = 32'h0000_0000;
    localparam int          RATE_FLOOR = 96000;
    localparam int          SAMPLE_W   = 32;
    localparam int          TAG_HI     = 31;
    localparam int          TAG_LO     = 24;
    localparam int          PAY_HI     = 23;
    localparam int          PAY_LO     = 8;
    localparam int          PAY_W      = PAY_HI - PAY_LO + 1;

    typedef enum logic {
        MODE_PCM = 1'b0,
        MODE_DOP = 1'b1
    } mode_e;
endpackage

// File: rtl/dop_marker_qual.sv
module dop_marker_qual
    import dop_pkg::*;
#(
    parameter int ENTRY_RUN = 32,
    parameter int RATE_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [7:0]        l_tag,
    input  logic [7:0]        r_tag,
    input  logic [RATE_W-1:0] rate_hz,
    output logic              dop_on,
    output logic              mode_pulse,
    output logic              exit_now
);
    localparam int CNT_W = $clog2(ENTRY_RUN + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ENTRY_RUN - 1);
    localparam logic [RATE_W-1:0] FLOOR_V = RATE_W'(RATE_FLOOR);

    typedef struct packed {
        mode_e            mode;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       expect_tag;
        logic             pulse;
    } qual_t;

    qual_t st_d, st_q;
    logic  rate_ok, l_has, r_has, pair_match;

    always_comb begin
        rate_ok    = rate_hz > FLOOR_V;
        l_has      = (l_tag == MARK_ODD) || (l_tag == MARK_EVEN);
        r_has      = (r_tag == MARK_ODD) || (r_tag == MARK_EVEN);
        pair_match = (l_tag == st_q.expect_tag) && (r_tag == st_q.expect_tag);
        exit_now   = frame_valid && (st_q.mode == MODE_DOP) && !l_has && !r_has;

        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (frame_valid) begin
            if (st_q.mode == MODE_PCM) begin
                if (rate_ok) begin
                    if (pair_match) begin
                        if (st_q.cnt == LAST_CNT) begin
                            st_d.mode       = MODE_DOP;
                            st_d.cnt        = '0;
                            st_d.expect_tag = MARK_EVEN;
                            st_d.pulse      = 1'b1;
                        end else begin
                            st_d.cnt        = st_q.cnt + 1'b1;
                            st_d.expect_tag = st_q.expect_tag ^ (MARK_ODD ^ MARK_EVEN);
                        end
                    end else begin
                        st_d.cnt        = '0;
                        st_d.expect_tag = MARK_EVEN;
                    end
                end
            end else if (exit_now) begin
                st_d.mode       = MODE_PCM;
                st_d.cnt        = '0;
                st_d.expect_tag = MARK_EVEN;
                st_d.pulse      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode       <= MODE_PCM;
            st_q.cnt        <= '0;
            st_q.expect_tag <= MARK_EVEN;
            st_q.pulse      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dop_on     = (st_q.mode == MODE_DOP);
    assign mode_pulse = st_q.pulse;

    AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pulse == (dop_on != $past(dop_on))); // R8
    AST_NO_ENTRY_LOW_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dop_on) |-> $past(rate_ok && frame_valid)); // R2
    AST_EXIT_NEEDS_BARE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dop_on) |-> $past(frame_valid && !l_has && !r_has)); // R7
endmodule

// File: rtl/dop_word_packer.sv
module dop_word_packer
    import dop_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic                restart,
    input  logic [SAMPLE_W-1:0] l_samp,
    input  logic [SAMPLE_W-1:0] r_samp,
    output logic                word_valid,
    output logic [2*PAY_W-1:0]  word_l,
    output logic [2*PAY_W-1:0]  word_r
);
    localparam int NCH = 2;

    typedef struct packed {
        logic                          half;
        logic [NCH-1:0][PAY_W-1:0]     hold;
        logic [NCH-1:0][2*PAY_W-1:0]   word;
        logic                          valid;
    } pack_t;

    pack_t st_d, st_q;
    logic [NCH-1:0][SAMPLE_W-1:0] samp;
    logic [NCH-1:0][PAY_W-1:0]    pay;

    assign samp[0] = l_samp;
    assign samp[1] = r_samp;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign pay[c] = samp[c][PAY_HI:PAY_LO];
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (restart) begin
            st_d.half = 1'b0;
        end else if (take) begin
            if (!st_q.half) begin
                st_d.hold = pay;
                st_d.half = 1'b1;
            end else begin
                for (int c = 0; c < NCH; c++) begin
                    st_d.word[c] = {st_q.hold[c], pay[c]};
                end
                st_d.valid = 1'b1;
                st_d.half  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_valid = st_q.valid;
    assign word_l     = st_q.word[0];
    assign word_r     = st_q.word[1];

    AST_WORD_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(take && !restart)); // R6
    AST_WORD_STABLE_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_l)); // R6
endmodule

// File: rtl/dop_bit_tick.sv
module dop_bit_tick #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic             tick;
    } tick_t;

    tick_t st_d, st_q;
    logic [PER_W:0] next_cnt;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        next_cnt  = {1'b0, st_q.cnt} + 1'b1;
        if (!run) begin
            st_d.cnt = '0;
        end else if (next_cnt >= {1'b0, period}) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = next_cnt[PER_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = st_q.tick;

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(run)); // R10
endmodule

// File: rtl/dop_unpacker.sv
module dop_unpacker
    import dop_pkg::*;
#(
    parameter int ENTRY_RUN = 32,
    parameter int RATE_W    = 32,
    parameter int PER_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_valid,
    input  logic [31:0]       pcm_left,
    input  logic [31:0]       pcm_right,
    input  logic [RATE_W-1:0] rate_hz,
    input  logic [PER_W-1:0]  bit_period,
    output logic              dop_mode,
    output logic              mode_change,
    output logic              dsd_valid,
    output logic [31:0]       dsd_left,
    output logic [31:0]       dsd_right,
    output logic              dsd_bit_en,
    output logic [31:0]       underflow_fill
);
    logic exit_now;
    logic take;

    dop_marker_qual #(
        .ENTRY_RUN (ENTRY_RUN),
        .RATE_W    (RATE_W)
    ) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .l_tag       (pcm_left[TAG_HI:TAG_LO]),
        .r_tag       (pcm_right[TAG_HI:TAG_LO]),
        .rate_hz     (rate_hz),
        .dop_on      (dop_mode),
        .mode_pulse  (mode_change),
        .exit_now    (exit_now)
    );

    assign take = frame_valid && dop_mode && !exit_now;

    dop_word_packer u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .restart    (!dop_mode || exit_now),
        .l_samp     (pcm_left),
        .r_samp     (pcm_right),
        .word_valid (dsd_valid),
        .word_l     (dsd_left),
        .word_r     (dsd_right)
    );

    dop_bit_tick #(
        .PER_W (PER_W)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (dop_mode),
        .period (bit_period),
        .tick   (dsd_bit_en)
    );

    assign underflow_fill = dop_mode ? FILL_DOP : FILL_PCM;

    AST_VALID_ONLY_IN_DOP: assert property (@(posedge clk) disable iff (!rst_n)
        dsd_valid |-> $past(dop_mode)); // R6
    AST_FILL_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dop_mode) |-> (underflow_fill == 32'hFA969600)); // R9
endmodule

// File: tb/dop_unpacker_bench.sv
module dop_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic [31:0] pcm_left = '0;
    logic [31:0] pcm_right = '0;
    logic [31:0] rate_hz = 32'd48000;
    logic [15:0] bit_period = 16'd4;
    logic        dop_mode, mode_change, dsd_valid, dsd_bit_en;
    logic [31:0] dsd_left, dsd_right, underflow_fill;

    int n_cmp = 0;
    int n_bad = 0;
    logic obs_valid, obs_pulse, obs_mode;

    always #10 clk = ~clk;

    dop_unpacker u_dop_unpacker (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
        .pcm_left(pcm_left), .pcm_right(pcm_right), .rate_hz(rate_hz),
        .bit_period(bit_period), .dop_mode(dop_mode), .mode_change(mode_change),
        .dsd_valid(dsd_valid), .dsd_left(dsd_left), .dsd_right(dsd_right),
        .dsd_bit_en(dsd_bit_en), .underflow_fill(underflow_fill)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [7:0] tag, input logic [15:0] pay);
        return {tag, pay, 8'h00};
    endfunction

    task automatic send_frame(input logic [31:0] l, input logic [31:0] r);
        @(negedge clk);
        pcm_left = l; pcm_right = r; frame_valid = 1'b1;
        @(negedge clk);
        obs_valid = dsd_valid; obs_pulse = mode_change; obs_mode = dop_mode;
        frame_valid = 1'b0;
    endtask

    task automatic send_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] t;
            t = (i % 2 == 0) ? 8'hFA : 8'h05;
            send_frame(mk(t, 16'(i)), mk(t, 16'(i + 7)));
        end
    endtask

    task automatic t_reset;
        check("R1 mode", {31'd0, dop_mode}, 32'd0);
        check("R1 pulse", {31'd0, mode_change}, 32'd0);
        check("R1 valid", {31'd0, dsd_valid}, 32'd0);
        check("R1 bit_en", {31'd0, dsd_bit_en}, 32'd0);
        check("R9 fill pcm", underflow_fill, 32'h0);
    endtask

    task automatic t_rate_gate;
        rate_hz = 32'd96000;
        send_run(40);
        check("R2 no entry at 96000", {31'd0, dop_mode}, 32'd0);
    endtask

    task automatic t_entry;
        rate_hz = 32'd192000;
        send_run(31);
        check("R3 one short", {31'd0, obs_mode}, 32'd0);
        send_frame(mk(8'h05, 16'h0), mk(8'h05, 16'h0));
        check("R3 entry", {31'd0, obs_mode}, 32'd1);
        check("R8 entry pulse", {31'd0, obs_pulse}, 32'd1);
        @(negedge clk);
        check("R8 pulse one cycle", {31'd0, mode_change}, 32'd0);
        check("R9 fill dop", underflow_fill, 32'hFA969600);
    endtask

    task automatic t_pack;
        send_frame(mk(8'h05, 16'h1234), mk(8'h05, 16'hABCD));
        check("R6 no word after first", {31'd0, obs_valid}, 32'd0);
        send_frame(mk(8'hFA, 16'h5678), mk(8'hFA, 16'h0F0F));
        check("R6 word valid", {31'd0, obs_valid}, 32'd1);
        check("R6 left word", dsd_left, 32'h12345678);
        check("R6 right word", dsd_right, 32'hABCD0F0F);
        @(negedge clk);
        check("R6 valid one cycle", {31'd0, dsd_valid}, 32'd0);
    endtask

    task automatic t_hold;
        send_frame(mk(8'h33, 16'hC0DE), mk(8'hFA, 16'h1111));
        check("R5 one-channel marker keeps", {31'd0, obs_mode}, 32'd1);
        send_frame(mk(8'h05, 16'hBEEF), mk(8'h77, 16'h2222));
        check("R5 other channel keeps", {31'd0, obs_mode}, 32'd1);
        check("R6 pair with odd tags", dsd_left, 32'hC0DEBEEF);
        check("R6 pair right", dsd_right, 32'h11112222);
        send_frame(mk(8'hFA, 16'h0), mk(8'hFA, 16'h0));
        send_frame(mk(8'hFA, 16'h0), mk(8'hFA, 16'h0));
        check("R5 repeated marker keeps", {31'd0, obs_mode}, 32'd1);
    endtask

    task automatic t_ticks(input logic exp_run);
        int cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (dsd_bit_en) cnt++;
        end
        check(exp_run ? "R10 tick rate" : "R10 no tick in pcm", cnt, exp_run ? 32'd10 : 32'd0);
    endtask

    task automatic t_exit;
        send_frame(mk(8'h05, 16'hDEAD), mk(8'h05, 16'hDEAD));
        send_frame(32'h0011_2233, 32'h4455_6677);
        check("R7 exit", {31'd0, obs_mode}, 32'd0);
        check("R8 exit pulse", {31'd0, obs_pulse}, 32'd1);
        check("R7 exit frame not packed", {31'd0, obs_valid}, 32'd0);
        check("R9 fill back", underflow_fill, 32'h0);
    endtask

    task automatic t_mismatch;
        send_run(31);
        send_frame(mk(8'h05, 16'h0), mk(8'h06, 16'h0));
        check("R4 bad right no entry", {31'd0, obs_mode}, 32'd0);
        send_frame(mk(8'h05, 16'h0), mk(8'h05, 16'h0));
        send_run(31);
        check("R4 restart needs full run", {31'd0, obs_mode}, 32'd0);
        send_frame(mk(8'h05, 16'h0), mk(8'h05, 16'h0));
        check("R4 entry after full run", {31'd0, obs_mode}, 32'd1);
    endtask

    task automatic t_phase_restart;
        send_frame(mk(8'hFA, 16'hAAAA), mk(8'hFA, 16'h5555));
        check("R7 fresh pair first half", {31'd0, obs_valid}, 32'd0);
        send_frame(mk(8'h05, 16'h1357), mk(8'h05, 16'h2468));
        check("R7 fresh pair valid", {31'd0, obs_valid}, 32'd1);
        check("R7 fresh pair left", dsd_left, 32'hAAAA1357);
        check("R7 fresh pair right", dsd_right, 32'h55552468);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rate_gate();
        t_entry();
        t_pack();
        t_hold();
        t_ticks(1'b1);
        t_exit();
        t_ticks(1'b0);
        t_mismatch();
        t_phase_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule